// File: doc/BRIEF.md
# Event-Triggered Memory Move Channels

A bank of independent move channels. Each channel holds a source pointer, a destination pointer, a countdown and a small control field. When a request pulse arrives for a channel, the channel takes one bus cycle and copies one byte or one data word from its source address to its destination address. It then advances the pointer that its control field names, by one byte or by one word, and decrements its countdown. The CPU loses only that one cycle. Its program is not suspended.

A channel whose countdown is already zero, and which is not in continuous mode, makes no move. It forwards the request as an ordinary interrupt for that same channel, so software can reload it. In continuous mode the countdown is frozen and every request causes a move. Requests that arrive in the same cycle are queued per channel, and the lowest-numbered pending channel is served first. The bus master is single-cycle. The read address and the write address, data and byte enables are all presented in the same cycle. Read data is expected back combinationally.

Top module: `evx_bank`

## Requirements
- R1: After reset every pointer, countdown and control field reads back as zero, and busy_o, mem_we_o, mem_re_o, done_o and irq_o are low.
- R2: A byte move (control bit 0 = 0) reads the byte lane that the low source address bit selects. It writes that byte to the lane that the low destination address bit selects, with exactly that one byte enable set.
- R3: A word move (control bit 0 = 1) copies the whole aligned data word, with all byte enables set.
- R4: After a move, only one pointer advances: the source pointer when control bit 1 = 0, the destination pointer when it is 1. It advances by 1 for byte moves and by 2 for word moves.
- R5: Each move decrements the channel's countdown by one when continuous mode (control bit 2) is off.
- R6: In continuous mode the countdown never changes, and a request makes a move even when the countdown is zero.
- R7: A request to a non-continuous channel whose countdown is zero makes no bus cycle and changes no pointer. It produces a one-cycle irq_o pulse, with irq_ch_o naming the channel, in the cycle after it is served.
- R8: When several channels are pending, one is served per cycle, in rising channel order. The others stay pending.
- R9: Each move asserts busy_o for exactly its one bus cycle. done_o pulses in the next cycle, with done_ch_o naming the channel, and the new pointer and countdown values are then readable.
- R10: A register write to a channel in the same cycle as that channel's move takes precedence for the written field. The move's updates to the other fields still apply.
- R11: A new request to a channel arriving in the cycle that channel is being served stays pending, and it is served in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Per-channel request pulses |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | CHW | Channel addressed by the write |
| cfg_fld_i | input | 2 | Field: 0 source, 1 destination, 2 countdown, 3 control |
| cfg_wdata_i | input | AW | Write data |
| rd_ch_i | input | CHW | Channel addressed by readback |
| rd_fld_i | input | 2 | Field to read back, same coding as writes |
| rd_data_o | output | AW | Readback value, zero-extended |
| busy_o | output | 1 | Stolen bus cycle in progress |
| mem_re_o | output | 1 | Memory read strobe |
| mem_raddr_o | output | AW | Byte read address |
| mem_rdata_i | input | DW | Read data word (combinational) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | AW | Byte write address |
| mem_wdata_o | output | DW | Write data word |
| mem_be_o | output | DW/8 | Write byte enables |
| done_o | output | 1 | Move completed (one cycle) |
| done_ch_o | output | CHW | Channel of the completed move |
| irq_o | output | 1 | Forwarded interrupt (one cycle) |
| irq_ch_o | output | CHW | Channel of the forwarded interrupt |

## Verification
Two pairs of events can coincide in one cycle. The first pair is a register write and a move on the same channel. The bench provokes it by driving the write in the cycle where busy_o is seen, and it requires the written source pointer to survive while the countdown still drops. The second pair is a fresh request and the service of that same channel. The bench repeats the request during the busy cycle and expects two back-to-back done pulses and a countdown lower by two. Priority is judged from the order of done_ch_o values after three simultaneous requests.

// File: rtl/evx_pkg.sv
package evx_pkg;
  typedef enum logic [1:0] {
    FLD_SRC = 2'd0,
    FLD_DST = 2'd1,
    FLD_CNT = 2'd2,
    FLD_CTL = 2'd3
  } fld_e;

  localparam int CTL_W    = 3;
  localparam int CTL_WORD = 0;  // 1: move a full data word
  localparam int CTL_BUMP = 1;  // 1: advance destination, 0: advance source
  localparam int CTL_CONT = 2;  // 1: countdown frozen
endpackage

// File: rtl/evx_prio.sv
module evx_prio #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = W'(i);
      end
    end
  end
endmodule

// File: rtl/evx_mover.sv
module evx_mover #(
  parameter int DW = 16,
  localparam int LANES = DW / 8,
  localparam int LB = $clog2(LANES)
) (
  input  logic             word,
  input  logic [LB-1:0]    src_lane,
  input  logic [LB-1:0]    dst_lane,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    wdata,
  output logic [LANES-1:0] be
);
  logic [7:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (src_lane == LB'(i)) pick = rdata[8*i +: 8];
    end
  end

  always_comb begin
    if (word) begin
      wdata = rdata;
      be    = '1;
    end else begin
      wdata = {LANES{pick}};
      be    = '0;
      for (int i = 0; i < LANES; i++) begin
        if (dst_lane == LB'(i)) be[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evx_chan.sv
module evx_chan
  import evx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  fld_e             wr_fld,
  input  logic [AW-1:0]    wr_data,
  input  logic             svc,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CW-1:0]    cnt_o,
  output logic [CTL_W-1:0] ctl_o
);
  logic [AW-1:0]    src_q, src_d, dst_q, dst_d, step;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             src_en, dst_en, cnt_en, ctl_en;

  assign step = ctl_q[CTL_WORD] ? AW'(LANES) : AW'(1);

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    ctl_d  = ctl_q;
    src_en = 1'b0;
    dst_en = 1'b0;
    cnt_en = 1'b0;
    ctl_en = 1'b0;
    if (svc) begin
      if (ctl_q[CTL_BUMP]) begin
        dst_d  = dst_q + step;
        dst_en = 1'b1;
      end else begin
        src_d  = src_q + step;
        src_en = 1'b1;
      end
      if (!ctl_q[CTL_CONT]) begin
        cnt_d  = cnt_q - CW'(1);
        cnt_en = 1'b1;
      end
    end
    if (wr_en) begin
      unique case (wr_fld)
        FLD_SRC: begin src_d = wr_data;            src_en = 1'b1; end
        FLD_DST: begin dst_d = wr_data;            dst_en = 1'b1; end
        FLD_CNT: begin cnt_d = wr_data[CW-1:0];    cnt_en = 1'b1; end
        FLD_CTL: begin ctl_d = wr_data[CTL_W-1:0]; ctl_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (src_en) src_q <= src_d;
      if (dst_en) dst_q <= dst_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign ctl_o = ctl_q;
endmodule

// File: rtl/evx_bank.sv
module evx_bank
  import evx_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LANES = DW / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_i,
  input  logic             cfg_we_i,
  input  logic [CHW-1:0]   cfg_ch_i,
  input  logic [1:0]       cfg_fld_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  input  logic [CHW-1:0]   rd_ch_i,
  input  logic [1:0]       rd_fld_i,
  output logic [AW-1:0]    rd_data_o,
  output logic             busy_o,
  output logic             mem_re_o,
  output logic [AW-1:0]    mem_raddr_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_waddr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [LANES-1:0] mem_be_o,
  output logic             done_o,
  output logic [CHW-1:0]   done_ch_o,
  output logic             irq_o,
  output logic [CHW-1:0]   irq_ch_o
);
  logic [NCH-1:0]   pend_q, pend_d, gnt, svc;
  logic [CHW-1:0]   gidx;
  logic             any, stop, xfer, fwd;
  logic [AW-1:0]    src_a [NCH];
  logic [AW-1:0]    dst_a [NCH];
  logic [CW-1:0]    cnt_a [NCH];
  logic [CTL_W-1:0] ctl_a [NCH];
  logic [AW-1:0]    src_s, dst_s;
  logic [CW-1:0]    cnt_s;
  logic [CTL_W-1:0] ctl_s;
  logic             done_q, irq_q;
  logic [CHW-1:0]   done_ch_q, irq_ch_q;

  evx_prio #(.N(NCH)) u_prio (
    .req (pend_q),
    .gnt (gnt),
    .idx (gidx),
    .any (any)
  );

  assign src_s = src_a[gidx];
  assign dst_s = dst_a[gidx];
  assign cnt_s = cnt_a[gidx];
  assign ctl_s = ctl_a[gidx];

  // A spent, non-continuous channel forwards instead of moving.
  assign stop = (cnt_s == '0) && !ctl_s[CTL_CONT];
  assign xfer = any && !stop;
  assign fwd  = any && stop;
  assign svc  = gnt & {NCH{xfer}};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      evx_chan #(.AW(AW), .CW(CW), .LANES(LANES)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we_i && (cfg_ch_i == CHW'(g))),
        .wr_fld  (fld_e'(cfg_fld_i)),
        .wr_data (cfg_wdata_i),
        .svc     (svc[g]),
        .src_o   (src_a[g]),
        .dst_o   (dst_a[g]),
        .cnt_o   (cnt_a[g]),
        .ctl_o   (ctl_a[g])
      );
    end
  endgenerate

  evx_mover #(.DW(DW)) u_mover (
    .word     (ctl_s[CTL_WORD]),
    .src_lane (src_s[LB-1:0]),
    .dst_lane (dst_s[LB-1:0]),
    .rdata    (mem_rdata_i),
    .wdata    (mem_wdata_o),
    .be       (mem_be_o)
  );

  // Served request clears; a new arrival in the same cycle re-arms it.
  assign pend_d = (pend_q & ~gnt) | req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      done_q    <= 1'b0;
      irq_q     <= 1'b0;
      done_ch_q <= '0;
      irq_ch_q  <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= xfer;
      irq_q  <= fwd;
      if (xfer) done_ch_q <= gidx;
      if (fwd)  irq_ch_q  <= gidx;
    end
  end

  always_comb begin
    unique case (fld_e'(rd_fld_i))
      FLD_SRC: rd_data_o = src_a[rd_ch_i];
      FLD_DST: rd_data_o = dst_a[rd_ch_i];
      FLD_CNT: rd_data_o = AW'(cnt_a[rd_ch_i]);
      default: rd_data_o = AW'(ctl_a[rd_ch_i]);
    endcase
  end

  assign busy_o      = xfer;
  assign mem_re_o    = xfer;
  assign mem_we_o    = xfer;
  assign mem_raddr_o = src_s;
  assign mem_waddr_o = dst_s;
  assign done_o      = done_q;
  assign done_ch_o   = done_ch_q;
  assign irq_o       = irq_q;
  assign irq_ch_o    = irq_ch_q;
endmodule

// File: rtl/evx_bank_chk.sv
module evx_bank_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             irq_o,
  input logic             mem_we_o,
  input logic [LANES-1:0] mem_be_o
);
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> done_o); // R9

  AST_FWD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(busy_o)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && irq_o)); // R8

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_be_o == '1 || $countones(mem_be_o) == 1)); // R2
endmodule

bind evx_bank evx_bank_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .irq_o    (irq_o),
  .mem_we_o (mem_we_o),
  .mem_be_o (mem_be_o)
);

// File: tb/evx_bank_tb_top.sv
`timescale 1ns/1ps
module evx_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req;
  logic        cfg_we;
  logic [2:0]  cfg_ch;
  logic [1:0]  cfg_fld;
  logic [15:0] cfg_wdata;
  logic [2:0]  rd_ch;
  logic [1:0]  rd_fld;
  logic [15:0] rd_data;
  logic        busy, mem_re, mem_we, done, irq;
  logic [15:0] mem_raddr, mem_waddr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;
  logic [2:0]  done_ch, irq_ch;

  logic [15:0] mem [256];
  logic [15:0] sh  [256];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evx_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_fld_i(cfg_fld), .cfg_wdata_i(cfg_wdata),
    .rd_ch_i(rd_ch), .rd_fld_i(rd_fld), .rd_data_o(rd_data),
    .busy_o(busy), .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .done_o(done), .done_ch_o(done_ch), .irq_o(irq), .irq_ch_o(irq_ch)
  );

  assign mem_rdata = mem[mem_raddr[8:1]];

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) mem[mem_waddr[8:1]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_waddr[8:1]][15:8] <= mem_wdata[15:8];
    end
  end

  function automatic logic [15:0] pat(input int i);
    logic [7:0] a;
    a = 8'(i);
    return {a ^ 8'h3C, 8'(a * 3) + 8'h17};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference move on the bench's own memory image.
  task automatic model_move(input int s, input int d, input bit w);
    logic [7:0] b;
    if (w) sh[d >> 1] = sh[s >> 1];
    else begin
      b = s[0] ? sh[s >> 1][15:8] : sh[s >> 1][7:0];
      if (d[0]) sh[d >> 1][15:8] = b;
      else      sh[d >> 1][7:0]  = b;
    end
  endtask

  task automatic cfg(input int ch, input int f, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_fld = 2'(f); cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rdf(input int ch, input int f, output int v);
    rd_ch = 3'(ch); rd_fld = 2'(f);
    #0.5;
    v = int'(rd_data);
  endtask

  task automatic setup(input int ch, input int s, input int d, input int c, input int ctl);
    cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, c); cfg(ch, 3, ctl);
  endtask

  // Returns at the negedge where the first service cycle is visible.
  task automatic pulse_req(input logic [7:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic serve(input int ch);
    pulse_req(8'(1 << ch));
    chk(busy === 1'b1, "R9 busy", int'(busy), 1);
    @(negedge clk);
    chk(done === 1'b1 && done_ch == 3'(ch), "R9 done", int'(done_ch), ch);
    chk(busy === 1'b0, "R9 single cycle", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, s, d, c, es, ed;
    rst_n = 1'b0; req = '0; cfg_we = 1'b0; cfg_ch = '0; cfg_fld = '0; cfg_wdata = '0;
    rd_ch = '0; rd_fld = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = (i < 128) ? pat(i) : 16'h0000;
      sh[i]  = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!busy && !mem_we && !mem_re && !done && !irq, "R1 outputs",
        int'({busy, mem_we, mem_re, done, irq}), 0);
    for (int ch = 0; ch < 8; ch++)
      for (int f = 0; f < 4; f++) begin
        rdf(ch, f, v);
        chk(v == 0, "R1 field", v, 0);
      end

    // Sweep: every channel, both sizes, both pointer choices.
    for (int ch = 0; ch < 8; ch++)
      for (int w = 0; w < 2; w++)
        for (int b = 0; b < 2; b++) begin
          s = ch * 20 + b * 6 + ((w == 0) ? (ch & 1) : 0);
          d = 256 + ch * 20 + b * 8 + w * 2 + ((w == 0) ? ((ch >> 1) & 1) : 0);
          c = 3 + ch;
          setup(ch, s, d, c, (b << 1) | w);
          model_move(s, d, w[0]);
          serve(ch);
          chk(mem[d >> 1] == sh[d >> 1], w ? "R3 word data" : "R2 byte data",
              int'(mem[d >> 1]), int'(sh[d >> 1]));
          es = (b == 0) ? s + (w ? 2 : 1) : s;
          ed = (b == 1) ? d + (w ? 2 : 1) : d;
          rdf(ch, 0, v); chk(v == es, "R4 source pointer", v, es);
          rdf(ch, 1, v); chk(v == ed, "R4 destination pointer", v, ed);
          rdf(ch, 2, v); chk(v == c - 1, "R5 countdown", v, c - 1);
        end

    // R7: spent channel forwards an interrupt.
    setup(3, 16'h30, 16'h1F0, 2, 0);
    model_move(16'h30, 16'h1F0, 1'b0); serve(3);
    model_move(16'h31, 16'h1F0, 1'b0); serve(3);
    for (int k = 0; k < 2; k++) begin
      pulse_req(8'h08);
      chk(busy === 1'b0 && mem_we === 1'b0, "R7 no bus cycle", int'(busy), 0);
      @(negedge clk);
      chk(irq === 1'b1 && irq_ch == 3'd3 && !done, "R7 forward", int'(irq_ch), 3);
      @(negedge clk);
      chk(irq === 1'b0, "R7 pulse width", int'(irq), 0);
      rdf(3, 0, v); chk(v == 16'h32, "R7 pointer kept", v, 16'h32);
      rdf(3, 2, v); chk(v == 0, "R7 countdown kept", v, 0);
      chk(mem[16'h1F0 >> 1] == sh[16'h1F0 >> 1], "R7 memory kept",
          int'(mem[16'h1F0 >> 1]), int'(sh[16'h1F0 >> 1]));
    end

    // R6: continuous mode at countdown zero still moves.
    setup(6, 16'h51, 16'h1E1, 0, 4);
    model_move(16'h51, 16'h1E1, 1'b0);
    serve(6);
    chk(mem[16'h1E1 >> 1] == sh[16'h1E1 >> 1], "R6 data", int'(mem[16'h1E1 >> 1]),
        int'(sh[16'h1E1 >> 1]));
    rdf(6, 2, v); chk(v == 0, "R6 countdown frozen", v, 0);
    rdf(6, 0, v); chk(v == 16'h52, "R6 pointer", v, 16'h52);

    // R8: simultaneous requests served in rising order.
    setup(2, 16'h10, 16'h1C0, 5, 0);
    setup(5, 16'h12, 16'h1C2, 5, 0);
    setup(7, 16'h14, 16'h1C4, 5, 0);
    pulse_req(8'hA4);
    chk(busy === 1'b1, "R8 first busy", int'(busy), 1);
    @(negedge clk);
    chk(done && done_ch == 3'd2, "R8 order first", int'(done_ch), 2);
    @(negedge clk);
    chk(done && done_ch == 3'd5, "R8 order second", int'(done_ch), 5);
    @(negedge clk);
    chk(done && done_ch == 3'd7, "R8 order third", int'(done_ch), 7);
    chk(busy === 1'b0, "R8 queue empty", int'(busy), 0);

    // R10: write and move on one channel in the same cycle.
    setup(1, 16'h40, 16'h1A0, 4, 0);
    @(negedge clk); req = 8'h02;
    @(negedge clk); req = '0;
    cfg_we = 1'b1; cfg_ch = 3'd1; cfg_fld = 2'd0; cfg_wdata = 16'h0077;
    chk(busy === 1'b1, "R10 busy", int'(busy), 1);
    @(negedge clk); cfg_we = 1'b0;
    rdf(1, 0, v); chk(v == 16'h77, "R10 write wins", v, 16'h77);
    rdf(1, 2, v); chk(v == 3, "R10 countdown still moves", v, 3);

    // R11: re-request during service stays pending.
    setup(4, 16'h60, 16'h190, 6, 2);
    @(negedge clk); req = 8'h10;
    @(negedge clk);
    chk(busy === 1'b1, "R11 first service", int'(busy), 1);
    @(negedge clk); req = '0;
    chk(done && busy, "R11 back to back", int'({done, busy}), 3);
    @(negedge clk);
    chk(done && !busy, "R11 second done", int'({done, busy}), 2);
    rdf(4, 2, v); chk(v == 4, "R11 countdown", v, 4);
    rdf(4, 1, v); chk(v == 16'h192, "R11 destination", v, 16'h192);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule